// File: doc/BRIEF.md
# Time-of-Day Counter with Freeze Control

This block keeps wall-clock time inside a chip from the system clock alone. A prescaler counts system cycles and, every `TICKS_PER_SEC` cycles, advances a chain of counters: seconds, then minutes, then hours, then a 9-bit day count. When the day count overflows it wraps to zero and raises a sticky overflow flag. A control register holds the day count's top bit, that overflow flag and a freeze bit. While the freeze bit is set, both the prescaler and the counters hold their values.

Software or a neighbouring block sets the time through a single-byte write port. A 3-bit select picks the register and an enable strobe commits the byte on the next clock edge. Every register is visible at all times on parallel output buses. Bus decoding, snapshot latching and battery backup are left to the surrounding logic. The prescaler terminal count is a parameter, so a simulation can run with a small value.

Top module: `tod_keeper`

## Requirements
- R1: The prescaler advances once per clock cycle while not frozen. On the cycle it reaches `TICKS_PER_SEC`-1 it wraps to 0 and advances seconds by one. After reset, seconds first reads 1 on the `TICKS_PER_SEC`-th clock edge.
- R2: Seconds and minutes each go from 59 to 0 and carry into the next counter. Hours go from 23 to 0 and carry into the day count. A counter changes only when the counter below it carries.
- R3: A seconds or minutes value of 60 to 63, or an hours value of 24 to 31, steps by one modulo its field width (64 or 32) when advanced, and gives no carry.
- R4: The day count is 9 bits. `day_lo_o` carries bits 7:0 and `day_hi_o[0]` carries bit 8. Each hour carry increments it.
- R5: When the day count advances from 0x1FF, it becomes 0 and `day_hi_o[7]` (overflow) is set.
- R6: The overflow flag stays set through further counting. Only a write to the day-high register can change it.
- R7: While `day_hi_o[6]` (freeze) is 1, no counter and not the prescaler advances. After the freeze is cleared, counting resumes from the held prescaler phase.
- R8: A write strobe with select 0 loads seconds from bits 5:0. Select 1 loads minutes from bits 5:0, select 2 loads hours from bits 4:0, and select 3 loads day bits 7:0 from bits 7:0. Select 4 loads overflow from bit 7, freeze from bit 6 and day bit 8 from bit 0. Bits 5:1 of `day_hi_o` always read 0.
- R9: When a write and a counter advance fall in the same cycle, the written register takes the write value. The other registers still advance using carries computed from the values held before the edge.
- R10: A write strobe with select 5, 6 or 7 changes no register.
- R11: While reset is asserted, all outputs read 0 and the prescaler is cleared, so the clock runs unfrozen after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, commits on the rising edge |
| wr_sel | input | 3 | Register select (0 sec, 1 min, 2 hr, 3 day low, 4 day high) |
| wr_data | input | 8 | Write data byte |
| sec_o | output | 6 | Seconds |
| min_o | output | 6 | Minutes |
| hr_o | output | 5 | Hours |
| day_lo_o | output | 8 | Day count bits 7:0 |
| day_hi_o | output | 8 | {overflow, freeze, 5'b0, day bit 8} |

## Verification
A write appears on the outputs one edge after it is presented. A second advance appears on the edge that ends the `TICKS_PER_SEC`-th unfrozen cycle, and every carry it causes lands on that same edge. A freeze written on edge N first suppresses counting on edge N+1. The bench drives inputs on falling edges and updates a bench-side reference on each rising edge, using the inputs and state from before that edge. It compares every output on the next falling edge, so each expectation is checked exactly one edge after its cause.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [2:0] {
    SEL_SEC = 3'd0,
    SEL_MIN = 3'd1,
    SEL_HR  = 3'd2,
    SEL_DLO = 3'd3,
    SEL_DHI = 3'd4
  } tod_sel_e;

  localparam int SEC_W   = 6;
  localparam int MIN_W   = 6;
  localparam int HR_W    = 5;
  localparam int DAY_W   = 9;
  localparam int SEC_TOP = 59;
  localparam int MIN_TOP = 59;
  localparam int HR_TOP  = 23;

  localparam int DH_OVF  = 7;
  localparam int DH_FRZ  = 6;
  localparam int DH_MSB  = 0;
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int TERM = 4194304
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (TERM > 2) ? $clog2(TERM) : 1;
  localparam logic [CW-1:0] LAST = CW'(TERM - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tod_wrap_ctr.sv
module tod_wrap_ctr #(
  parameter int W   = 6,
  parameter int TOP = 59
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic         carry
);
  localparam logic [W-1:0] TOP_V = W'(TOP);

  logic at_top;

  assign at_top = (value == TOP_V);
  assign carry  = inc && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (wr) begin
      value <= wdata;
    end else if (inc) begin
      value <= at_top ? '0 : value + 1'b1;
    end
  end
endmodule

// File: rtl/tod_day_ctr.sv
module tod_day_ctr
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wdata,
  output logic [7:0] day_lo,
  output logic [7:0] day_hi,
  output logic       frozen
);
  logic [DAY_W-1:0] day_q;
  logic             ovf_q;
  logic             frz_q;
  logic [DAY_W:0]   sum;

  assign sum = {1'b0, day_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day_q <= '0;
      ovf_q <= 1'b0;
      frz_q <= 1'b0;
    end else begin
      if (wr_lo)    day_q[7:0] <= wdata;
      else if (inc) day_q[7:0] <= sum[7:0];

      if (wr_hi)    day_q[8] <= wdata[DH_MSB];
      else if (inc) day_q[8] <= sum[8];

      if (wr_hi)                ovf_q <= wdata[DH_OVF];
      else if (inc && sum[DAY_W]) ovf_q <= 1'b1;

      if (wr_hi) frz_q <= wdata[DH_FRZ];
    end
  end

  assign day_lo = day_q[7:0];
  assign day_hi = {ovf_q, frz_q, 5'b00000, day_q[8]};
  assign frozen = frz_q;
endmodule

// File: rtl/tod_keeper.sv
module tod_keeper
  import tod_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4194304
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [5:0] sec_o,
  output logic [5:0] min_o,
  output logic [4:0] hr_o,
  output logic [7:0] day_lo_o,
  output logic [7:0] day_hi_o
);
  logic sec_tick, frozen;
  logic sec_cy, min_cy, hr_cy;
  logic w_sec, w_min, w_hr, w_dlo, w_dhi;

  always_comb begin
    w_sec = 1'b0; w_min = 1'b0; w_hr = 1'b0; w_dlo = 1'b0; w_dhi = 1'b0;
    if (wr_en) begin
      case (tod_sel_e'(wr_sel))
        SEL_SEC: w_sec = 1'b1;
        SEL_MIN: w_min = 1'b1;
        SEL_HR:  w_hr  = 1'b1;
        SEL_DLO: w_dlo = 1'b1;
        SEL_DHI: w_dhi = 1'b1;
        default: ;
      endcase
    end
  end

  tod_prescaler #(.TERM(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(!frozen), .tick(sec_tick)
  );

  tod_wrap_ctr #(.W(SEC_W), .TOP(SEC_TOP)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(sec_tick), .wr(w_sec),
    .wdata(wr_data[SEC_W-1:0]), .value(sec_o), .carry(sec_cy)
  );

  tod_wrap_ctr #(.W(MIN_W), .TOP(MIN_TOP)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(sec_cy), .wr(w_min),
    .wdata(wr_data[MIN_W-1:0]), .value(min_o), .carry(min_cy)
  );

  tod_wrap_ctr #(.W(HR_W), .TOP(HR_TOP)) u_hr (
    .clk(clk), .rst_n(rst_n), .inc(min_cy), .wr(w_hr),
    .wdata(wr_data[HR_W-1:0]), .value(hr_o), .carry(hr_cy)
  );

  tod_day_ctr u_day (
    .clk(clk), .rst_n(rst_n), .inc(hr_cy), .wr_lo(w_dlo), .wr_hi(w_dhi),
    .wdata(wr_data), .day_lo(day_lo_o), .day_hi(day_hi_o), .frozen(frozen)
  );
endmodule

// File: rtl/tod_keeper_chk.sv
module tod_keeper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [5:0] sec_o,
  input logic [5:0] min_o,
  input logic [4:0] hr_o,
  input logic [7:0] day_lo_o,
  input logic [7:0] day_hi_o,
  input logic       tick
);
  a_r7_no_tick_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    day_hi_o[6] |-> !tick);

  a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (day_hi_o[6] && !wr_en) |=> $stable({sec_o, min_o, hr_o, day_lo_o, day_hi_o}));

  a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && sec_o != 6'd59) |=> (sec_o == $past(sec_o) + 6'd1));

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && sec_o == 6'd59) |=> (sec_o == 6'd0));

  a_r5_day_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && sec_o == 6'd59 && min_o == 6'd59 && hr_o == 5'd23 &&
     day_lo_o == 8'hFF && day_hi_o[0]) |=> (day_hi_o[7] && day_lo_o == 8'h00 && !day_hi_o[0]));

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (day_hi_o[7] && !(wr_en && wr_sel == 3'd4)) |=> day_hi_o[7]);

  a_r10_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel > 3'd4 && !tick) |=> $stable({sec_o, min_o, hr_o, day_lo_o, day_hi_o}));
endmodule

bind tod_keeper tod_keeper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .day_lo_o(day_lo_o),
  .day_hi_o(day_hi_o), .tick(sec_tick)
);

// File: tb/tod_keeper_bench.sv
module tod_keeper_bench;
  localparam int CLK_P = 10;
  localparam int TERM  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] sec_o, min_o;
  logic [4:0] hr_o;
  logic [7:0] day_lo_o, day_hi_o;

  int checks = 0;
  int failures = 0;
  string cur_req = "R11";

  int m_pc, m_sec, m_min, m_hr, m_day;
  bit m_ovf, m_frz;

  always #(CLK_P/2) clk = ~clk;

  tod_keeper #(.TICKS_PER_SEC(TERM)) u_tod_keeper (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .day_lo_o(day_lo_o), .day_hi_o(day_hi_o)
  );

  // Reference: advance first from pre-edge state, then apply any write on top.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_ovf = 0; m_frz = 0;
    end else begin
      bit t, cs, cm, ch;
      t = !m_frz && (m_pc == TERM - 1);
      if (!m_frz) m_pc = (m_pc == TERM - 1) ? 0 : m_pc + 1;
      if (t) begin
        cs = (m_sec == 59);
        m_sec = cs ? 0 : (m_sec + 1) % 64;
        if (cs) begin
          cm = (m_min == 59);
          m_min = cm ? 0 : (m_min + 1) % 64;
          if (cm) begin
            ch = (m_hr == 23);
            m_hr = ch ? 0 : (m_hr + 1) % 32;
            if (ch) begin
              if (m_day == 511) begin m_day = 0; m_ovf = 1; end
              else m_day = m_day + 1;
            end
          end
        end
      end
      if (wr_en) begin
        case (wr_sel)
          3'd0: m_sec = wr_data & 8'h3F;
          3'd1: m_min = wr_data & 8'h3F;
          3'd2: m_hr  = wr_data & 8'h1F;
          3'd3: m_day = (m_day & 256) | wr_data;
          3'd4: begin
            m_day = (m_day & 255) | (wr_data[0] ? 256 : 0);
            m_frz = wr_data[6];
            m_ovf = wr_data[7];
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cmp_all();
    logic [7:0] exp_hi;
    exp_hi = {m_ovf, m_frz, 5'b0, m_day[8]};
    checks++;
    if (sec_o != m_sec[5:0] || min_o != m_min[5:0] || hr_o != m_hr[4:0] ||
        day_lo_o != m_day[7:0] || day_hi_o != exp_hi) begin
      failures++;
      $display("FAIL %s actual=%0d:%0d:%0d d=%0h/%0h expected=%0d:%0d:%0d d=%0h/%0h",
               cur_req, hr_o, min_o, sec_o, day_hi_o, day_lo_o,
               m_hr, m_min, m_sec, exp_hi, m_day[7:0]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic finish_up();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11", {sec_o, min_o, hr_o, day_lo_o, day_hi_o}, 0);
    rst_n = 1'b1;

    cur_req = "R1";
    run(TERM - 1);
    chk("R1", sec_o, 0);
    step();
    chk("R1", sec_o, 1);
    run(4 * TERM);

    cur_req = "R2";
    run(200 * TERM);
    for (int h = 0; h < 24; h++) begin
      wr(3'd2, 8'(h));
      wr(3'd1, 8'd59);
      wr(3'd0, 8'd59);
      cur_req = "R4";
      run(2 * TERM);
      cur_req = "R2";
    end
    chk("R4", {day_hi_o[0], day_lo_o} > 0, 1);

    cur_req = "R3";
    wr(3'd4, 8'h40);
    wr(3'd0, 8'd63);
    wr(3'd1, 8'd60);
    wr(3'd2, 8'd31);
    wr(3'd4, 8'h00);
    run(4 * TERM);

    cur_req = "R8";
    wr(3'd4, 8'h40);
    wr(3'd0, 8'hFF); chk("R8", sec_o, 63);
    wr(3'd1, 8'hFF); chk("R8", min_o, 63);
    wr(3'd2, 8'hFF); chk("R8", hr_o, 31);
    wr(3'd3, 8'hAB); chk("R8", day_lo_o, 8'hAB);
    wr(3'd4, 8'hFF); chk("R8", day_hi_o, 8'hC1);

    cur_req = "R10";
    for (int s = 5; s < 8; s++) wr(3'(s), 8'h00);
    chk("R10", {sec_o, min_o, hr_o, day_lo_o, day_hi_o}, {6'd63, 6'd63, 5'd31, 8'hAB, 8'hC1});

    cur_req = "R7";
    run(10 * TERM);
    chk("R7", sec_o, 63);

    cur_req = "R6";
    wr(3'd4, 8'h41); chk("R6", day_hi_o, 8'h41);

    cur_req = "R5";
    wr(3'd0, 8'd59);
    wr(3'd1, 8'd59);
    wr(3'd2, 8'd23);
    wr(3'd3, 8'hFF);
    wr(3'd4, 8'h01);
    run(2 * TERM);
    chk("R5", day_hi_o[7], 1);
    chk("R5", {day_hi_o[0], day_lo_o}, 0);

    cur_req = "R6";
    run(200 * TERM);
    chk("R6", day_hi_o[7], 1);
    wr(3'd4, 8'h00); chk("R6", day_hi_o[7], 0);

    cur_req = "R7";
    wr(3'd4, 8'h40);
    run(5);
    wr(3'd4, 8'h00);
    run(3 * TERM);

    cur_req = "R9";
    wr(3'd4, 8'h40);
    wr(3'd0, 8'd59);
    wr(3'd1, 8'd10);
    wr(3'd4, 8'h00);
    for (int i = 0; i < TERM && m_pc != TERM - 1; i++) step();
    wr(3'd0, 8'd7);
    chk("R9", sec_o, 7);
    chk("R9", min_o, 11);
    run(2 * TERM);

    cur_req = "R11";
    rst_n = 1'b0;
    #1;
    chk("R11", {sec_o, min_o, hr_o, day_lo_o, day_hi_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run(TERM);
    chk("R11", sec_o, 1);

    finish_up();
  end
endmodule